// File: doc/BRIEF.md
# Moore/Mealy Behaviour Classifier

This block is a test sequencer for an external sequential circuit whose internal structure is unknown. It drives the circuit's input word bus, issues single-cycle clock strobes to it, and watches its output word. From these observations it decides whether the circuit's outputs are a function of internal state alone (Moore behaviour) or are also wired combinationally to the inputs (Mealy behaviour).

A run is a series of rounds. In each round the engine drives a pseudo-random word and clocks the circuit once. It then drives word zero and keeps the response as a reference. After that it steps through every other input word with the clock held off. If any response differs from the reference, the circuit's output depends on its inputs, and the run stops at once with a Mealy verdict. If a whole round shows no change, another clocked random step follows. This continues until the programmed number of rounds is used up, and then the verdict is Moore. The engine reports the verdict, a done flag, and the round in which it decided.

Engine states: `ST_IDLE` (waiting for start), `ST_STIR` (drive random word), `ST_STROBE` (one-cycle clock strobe), `ST_REFER` (drive word zero, capture reference), `ST_SWEEP` (step the remaining words, compare), and `ST_DONE` (verdict held). The transitions are:
- idle→stir and done→stir on start.
- stir→strobe when settling completes.
- strobe→refer always.
- refer→sweep when settling completes.
- sweep→done on a mismatch.
- sweep→stir after the last word of a round that is not the final round.
- sweep→done after the last word of the final round.

Top module: `fsm_kind_classifier`

## Requirements
- R1: After reset, `cut_clk` is low, `cut_in` is 0, `done` is low, `is_mealy` is low and `decide_round` is 0.
- R2: Every round drives a random word on `cut_in` and then raises `cut_clk` for exactly one cycle while that word is still driven. The number of strobes in a run equals the reported `decide_round`.
- R3: In the cycle after a strobe, `cut_in` is 0. The circuit's output for word 0, once settled, is stored as that round's reference.
- R4: The words 1 to 2^IN_W-1 are then driven in ascending order with no strobe. The first output that differs from the reference moves the engine straight to done, with `is_mealy`=1 and `decide_round` set to the current round number (counted from 1).
- R5: Every word the engine drives is held for `settle_cycles`+1 cycles, and the output is sampled in the last of them. A clean round therefore lasts 1+(settle_cycles+1)·(2^IN_W+1) cycles.
- R6: When every round matches, the run ends after `max_rounds` rounds with `is_mealy`=0 and `decide_round`=`max_rounds`. A value of 0 is treated as 1.
- R7: Random words come from a 16-bit LFSR that shifts toward the MSB and feeds bits 15^13^12^10 into bit 0. The LFSR is loaded from `seed` on start, with a zero seed replaced by 0x0001. It advances once per strobe, and the low IN_W bits of its state give the round's word.
- R8: `done`, `is_mealy` and `decide_round` hold their values until the next start. A start pulse that arrives while a run is in progress has no effect. `seed`, `max_rounds` and `settle_cycles` are captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken in idle or done) |
| max_rounds | input | CNT_W | Number of clocked rounds before a Moore verdict |
| seed | input | 16 | LFSR seed |
| settle_cycles | input | SET_W | Extra hold cycles per driven word |
| cut_in | output | IN_W | Input word to the circuit under test |
| cut_clk | output | 1 | Single-cycle clock strobe to the circuit under test |
| cut_out | input | OUT_W | Output word of the circuit under test |
| done | output | 1 | Verdict valid |
| is_mealy | output | 1 | 1 = Mealy, 0 = Moore |
| decide_round | output | CNT_W | Round at which the verdict was reached |

## Verification
The assertions check several properties on every cycle:
- the strobe lasts only one cycle;
- word zero follows each strobe;
- no strobe appears once done;
- the driven word stays stable while a settle count runs;
- the verdict holds in done;
- the LFSR never reaches the all-zero state.

Other behaviours can only be shown by the bench's scenarios, which run the sequence against modelled Moore and Mealy circuits:
- that a mismatch ends the run on the exact round and word;
- that the total run length matches the settle-dependent formula;
- that a zero seed and a zero round count are substituted;
- that a start pulse in mid-run leaves the run untouched.

// File: rtl/fkc_pkg.sv
package fkc_pkg;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SAFE_SEED = 16'h0001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STIR,
        ST_STROBE,
        ST_REFER,
        ST_SWEEP,
        ST_DONE
    } fkc_state_e;

endpackage

// File: rtl/fkc_lfsr.sv
module fkc_lfsr
    import fkc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    input  logic              step,
    output logic [LFSR_W-1:0] q
);

    logic fb;

    // taps 16,14,13,11 of a maximal-length sequence
    assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= LFSR_SAFE_SEED;
        end else if (load) begin
            q <= (seed == '0) ? LFSR_SAFE_SEED : seed;
        end else if (step) begin
            q <= {q[LFSR_W-2:0], fb};
        end
    end

    // R7: the register must never lock up in the all-zero state
    a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);

endmodule

// File: rtl/fkc_settle_timer.sv
module fkc_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/fsm_kind_classifier.sv
module fsm_kind_classifier
    import fkc_pkg::*;
#(
    parameter int IN_W  = 3,
    parameter int OUT_W = 4,
    parameter int CNT_W = 16,
    parameter int SET_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  max_rounds,
    input  logic [LFSR_W-1:0] seed,
    input  logic [SET_W-1:0]  settle_cycles,
    output logic [IN_W-1:0]   cut_in,
    output logic              cut_clk,
    input  logic [OUT_W-1:0]  cut_out,
    output logic              done,
    output logic              is_mealy,
    output logic [CNT_W-1:0]  decide_round
);

    localparam logic [IN_W-1:0]  LAST_WORD = {IN_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE_ROUND = {{(CNT_W-1){1'b0}}, 1'b1};

    fkc_state_e         state_q, state_d;
    logic [IN_W-1:0]    word_q;
    logic [OUT_W-1:0]   ref_q;
    logic [CNT_W-1:0]   round_q;
    logic [CNT_W-1:0]   max_q;
    logic [SET_W-1:0]   settle_q;
    logic               mealy_q;
    logic [CNT_W-1:0]   decide_q;
    logic [LFSR_W-1:0]  rnd_q;

    logic               expired;
    logic               start_run;
    logic               sample_now;
    logic               mismatch;
    logic               word_wrap;
    logic               final_round;
    logic               timer_load;
    logic [SET_W-1:0]   timer_val;

    // ---------------- control decode ----------------
    always_comb begin
        start_run   = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
        sample_now  = (state_q == ST_SWEEP) && expired;
        mismatch    = sample_now && (cut_out != ref_q);
        word_wrap   = (word_q == LAST_WORD);
        final_round = (round_q >= max_q);
        timer_load  = start_run
                   || (state_q == ST_STROBE)
                   || ((state_q == ST_REFER) && expired)
                   || (sample_now && !mismatch && !(word_wrap && final_round));
        timer_val   = start_run ? settle_cycles : settle_q;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_STIR;
            ST_STIR:   if (expired) state_d = ST_STROBE;
            ST_STROBE: state_d = ST_REFER;
            ST_REFER:  if (expired) state_d = ST_SWEEP;
            ST_SWEEP: begin
                if (sample_now) begin
                    if (mismatch) begin
                        state_d = ST_DONE;
                    end else if (word_wrap) begin
                        state_d = final_round ? ST_DONE : ST_STIR;
                    end
                end
            end
            ST_DONE:   if (start) state_d = ST_STIR;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            ref_q    <= '0;
            round_q  <= '0;
            max_q    <= ONE_ROUND;
            settle_q <= '0;
            mealy_q  <= 1'b0;
            decide_q <= '0;
        end else begin
            if (start_run) begin
                round_q  <= ONE_ROUND;
                max_q    <= (max_rounds == '0) ? ONE_ROUND : max_rounds;
                settle_q <= settle_cycles;
                mealy_q  <= 1'b0;
                decide_q <= '0;
            end
            if (state_q == ST_STROBE) begin
                word_q <= '0;
            end
            if ((state_q == ST_REFER) && expired) begin
                ref_q  <= cut_out;
                word_q <= {{(IN_W-1){1'b0}}, 1'b1};
            end
            if (sample_now && !mismatch && !word_wrap) begin
                word_q <= word_q + 1'b1;
            end
            if (mismatch) begin
                mealy_q  <= 1'b1;
                decide_q <= round_q;
            end
            if (sample_now && !mismatch && word_wrap) begin
                if (final_round) begin
                    mealy_q  <= 1'b0;
                    decide_q <= round_q;
                end else begin
                    round_q <= round_q + 1'b1;
                end
            end
        end
    end

    // ---------------- sub-blocks ----------------
    fkc_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_run),
        .seed  (seed),
        .step  (state_q == ST_STROBE),
        .q     (rnd_q)
    );

    fkc_settle_timer #(.W(SET_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (expired)
    );

    // ---------------- outputs ----------------
    always_comb begin
        cut_in  = '0;
        cut_clk = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:   cut_in = '0;
            ST_STIR:   cut_in = rnd_q[IN_W-1:0];
            ST_STROBE: begin
                cut_in  = rnd_q[IN_W-1:0];
                cut_clk = 1'b1;
            end
            ST_REFER:  cut_in = word_q;
            ST_SWEEP:  cut_in = word_q;
            ST_DONE:   done = 1'b1;
            default:   cut_in = '0;
        endcase
    end

    assign is_mealy     = mealy_q;
    assign decide_round = decide_q;

    // ---------------- assertions ----------------
    // R2: a strobe is exactly one cycle wide
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cut_clk |=> !cut_clk);

    // R3: word zero is presented right after every strobe
    a_r3_zero_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cut_clk) |-> (cut_in == '0));

    // R4: no strobe once a verdict is out
    a_r4_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cut_clk);

    // R5: driven word stays put while the settle timer runs
    a_r5_hold_while_settling: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == ST_STIR) || (state_q == ST_REFER) || (state_q == ST_SWEEP))
         && !expired) |=> $stable(cut_in));

    // R8: verdict is held until the next start
    a_r8_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(is_mealy) && $stable(decide_round)));

endmodule

// File: tb/test_fsm_kind_classifier.sv
`timescale 1ns/1ps
module test_fsm_kind_classifier;

    localparam int IN_W  = 3;
    localparam int OUT_W = 4;
    localparam int CNT_W = 16;
    localparam int SET_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  max_rounds = '0;
    logic [15:0]       seed = '0;
    logic [SET_W-1:0]  settle_cycles = '0;
    logic [IN_W-1:0]   cut_in;
    logic              cut_clk;
    logic [OUT_W-1:0]  cut_out;
    logic              done;
    logic              is_mealy;
    logic [CNT_W-1:0]  decide_round;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // ---------- modelled circuit under test ----------
    logic [2:0] cut_st;
    bit         cut_is_mealy = 1'b0;

    function automatic logic [2:0] cut_next(input logic [2:0] st, input logic [2:0] w);
        return 3'((st * 5 + w + 3) & 7);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) cut_st <= 3'd0;
        else if (cut_clk) cut_st <= cut_next(cut_st, cut_in);
    end

    always_comb begin
        if (cut_is_mealy) cut_out = {cut_st, (cut_st == 3'd5) && (cut_in == 3'd6)};
        else              cut_out = {cut_st, ^cut_st};
    end

    fsm_kind_classifier #(
        .IN_W(IN_W), .OUT_W(OUT_W), .CNT_W(CNT_W), .SET_W(SET_W)
    ) i_fsm_kind_classifier (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .max_rounds    (max_rounds),
        .seed          (seed),
        .settle_cycles (settle_cycles),
        .cut_in        (cut_in),
        .cut_clk       (cut_clk),
        .cut_out       (cut_out),
        .done          (done),
        .is_mealy      (is_mealy),
        .decide_round  (decide_round)
    );

    // ---------- bench helpers ----------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lfsr_step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // expected verdict, round and run length from the requirements
    task automatic predict(input logic [2:0] st0, input logic [15:0] sd, input int maxr,
                           input int st_cyc, input bit mealy,
                           output bit e_mealy, output int e_round, output int e_cycles);
        logic [15:0] lf;
        logic [2:0]  st;
        int eff, len;
        bit found;
        lf = (sd == 16'h0) ? 16'h0001 : sd;
        st = st0;
        eff = (maxr == 0) ? 1 : maxr;
        len = 1 + (st_cyc + 1) * ((1 << IN_W) + 1);
        found = 1'b0;
        e_mealy = 1'b0; e_round = eff; e_cycles = eff * len;
        for (int k = 1; k <= eff; k++) begin
            if (!found) begin
                st = cut_next(st, lf[2:0]);
                lf = lfsr_step(lf);
                if (mealy && st == 3'd5) begin
                    found = 1'b1;
                    e_mealy = 1'b1;
                    e_round = k;
                    e_cycles = (k - 1) * len + 1 + (st_cyc + 1) * (2 + 6);
                end
            end
        end
    endtask

    task automatic run(input logic [15:0] sd, input int maxr, input int st_cyc,
                       input bit mealy, input bit poke);
        bit e_mealy;
        int e_round, e_cycles, cyc, pulses;
        logic [CNT_W-1:0] held_round;
        bit held_mealy;
        cut_is_mealy = mealy;
        predict(cut_st, sd, maxr, st_cyc, mealy, e_mealy, e_round, e_cycles);
        seed = sd;
        max_rounds = CNT_W'(maxr);
        settle_cycles = SET_W'(st_cyc);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        // R8: the inputs are captured at start, so disturb them afterwards
        seed = ~sd;
        settle_cycles = SET_W'(st_cyc + 2);
        cyc = 0;
        pulses = 0;
        while (!done && cyc < 40000) begin
            start = (poke && cyc == 4);
            @(negedge clk);
            cyc++;
            if (cut_clk) pulses++;
        end
        start = 1'b0;
        check(is_mealy == e_mealy, "R4 R6 verdict", int'(is_mealy), int'(e_mealy));
        check(int'(decide_round) == e_round, "R3 R4 R6 decide_round", int'(decide_round), e_round);
        check(cyc == e_cycles, poke ? "R8 busy start ignored, R5 run length" : "R5 run length",
              cyc, e_cycles);
        check(pulses == e_round, "R2 strobe count", pulses, e_round);
        held_round = decide_round;
        held_mealy = is_mealy;
        repeat (10) @(negedge clk);
        check(done && is_mealy == held_mealy && decide_round == held_round,
              "R8 verdict held", int'(decide_round), int'(held_round));
    endtask

    // ---------- watchdog ----------
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------- main sequence ----------
    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cut_clk == 1'b0, "R1 cut_clk", int'(cut_clk), 0);
        check(cut_in == '0, "R1 cut_in", int'(cut_in), 0);
        check(done == 1'b0 && is_mealy == 1'b0, "R1 done/is_mealy", int'(done), 0);
        check(decide_round == '0, "R1 decide_round", int'(decide_round), 0);

        run(16'h1234, 5, 0, 1'b0, 1'b0);   // Moore, no settle
        run(16'hACE1, 0, 2, 1'b0, 1'b0);   // R6 zero rounds act as one
        run(16'h0000, 12, 1, 1'b1, 1'b0);  // R7 zero seed substitution
        run(16'hBEEF, 60, 3, 1'b1, 1'b0);  // Mealy, long settle
        run(16'h5A5A, 40, 1, 1'b1, 1'b1);  // R8 start poke during run
        run(16'h0F0F, 300, 1, 1'b0, 1'b0); // long Moore run
        for (int i = 0; i < 16; i++) begin
            run(16'($urandom_range(0, 65535)), int'($urandom_range(0, 25)),
                int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule